// File: doc/BRIEF.md
# Manchester II Word Encoder

This block turns one 16-bit word, fetched bit by bit from an external serial source, into a framed Manchester II stream on a pair of active-low bipolar line outputs. A frame lasts 20 bit times. It opens with a 3-bit-time sync pattern, which is 1.5 bit times at one line polarity and then 1.5 bit times at the other, and its order shows whether the word is a command word or a data word. The 16 data bits follow, MSB first. The frame closes with one odd parity bit.

The block runs from a single clock at 12 times the bit rate. It divides that clock internally, first into a half-bit rhythm (the 2x send clock) and then into a shift clock at the bit rate, which it drives out. The serial source watches the send-data request together with the shift clock. It changes its data on falling edges of the shift clock, and the encoder samples that data on rising edges. If enable stays high, frames follow one another with no gap. An active-low inhibit blanks the line outputs and leaves the encoder running. The synchronous active-low reset acts as master reset: it clears both dividers and abandons any word in flight.

Top module: `mwe_encoder`

## Requirements
- R1: The shift clock is high for 6 clock cycles and low for 6 in turn. It is high during reset, and its first falling edge comes 6 clock edges after reset is released.
- R2: A frame starts at the rising edge of the shift clock that follows a falling edge at which enable was sampled high while the encoder was idle. The frame lasts 20 shift-clock periods (240 clock cycles).
- R3: Sync select is sampled at the rising edge that starts the frame. With a high, the line is positive for 3 half-bits and then negative for 3 half-bits. With a low, the order is reversed. Changes to sync select at other times have no effect.
- R4: Send-data is high for exactly 16 shift-clock periods. It rises at the falling shift-clock edge in the third sync bit and falls at the falling edge in the last data bit.
- R5: Serial data is sampled on the 16 rising shift-clock edges that start the data bits. The first sample is the MSB. Serial data outside those edges has no effect.
- R6: A data bit of 1 is sent as a positive half and then a negative half. A 0 is sent as a negative half and then a positive half. A positive half drives only the one output low, a negative half drives only the zero output low, and both outputs are never low together.
- R7: The bit after the data is the parity bit. It is chosen so that the 16 data bits plus parity hold an odd number of ones, and it is encoded like a data bit.
- R8: The enable value sampled at the falling edge inside the parity bit decides what happens next. A high starts the next frame directly after the parity bit. A low returns the encoder to idle.
- R9: While inhibit is low, both line outputs are high. Frame timing, the divider and the send-data request carry on unchanged.
- R10: Reset low at a clock edge clears both dividers and any frame in progress. Afterwards the shift clock is high, send-data is low and both line outputs are high.
- R11: While idle, both line outputs are high and send-data is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 12x the bit rate |
| rst_n | input | 1 | Synchronous active-low master reset |
| enable_i | input | 1 | Requests a frame; sampled on falling shift-clock edges |
| sync_sel_i | input | 1 | 1 = command sync, 0 = data sync; sampled at frame start |
| sdi_i | input | 1 | Serial word data from the external source |
| inhibit_n_i | input | 1 | Low forces both line outputs high |
| sclk_o | output | 1 | Shift clock at the bit rate |
| send_data_o | output | 1 | High while the encoder wants the 16 data bits |
| line_one_n_o | output | 1 | Active-low positive-sense line drive |
| line_zero_n_o | output | 1 | Active-low negative-sense line drive |

## Verification
A divider phase error shows on the shift clock within 6 cycles. It also moves every later line transition. A slot counter or sync capture error shows within one half-bit (6 cycles) as a wrong line level or a misplaced send-data edge. An error in the running parity accumulator stays hidden until the parity bit, which can be up to 240 cycles after its cause. For that reason the words include all-zero, all-one and mixed patterns, and the bench compares every port on every cycle against a behavioural model.

// File: rtl/mwe_pkg.sv
// Shared types for the Manchester II word encoder.
package mwe_pkg;

    // Bus condition requested for the current half-bit.
    typedef enum logic [1:0] {
        LVL_IDLE = 2'd0,
        LVL_POS  = 2'd1,
        LVL_NEG  = 2'd2
    } line_lvl_e;

endpackage

// File: rtl/mwe_clkdiv.sv
// Clock divider.
// Divides the 12x clock by DIV_SEND to get half-bit ticks (the 2x send
// clock) and toggles a half flag on each tick, which gives the 1x shift
// clock. Tick outputs are single-cycle strobes that are high in the cycle
// before the shift clock edge they announce.
// Assumes: synchronous active-low reset; the shift clock is high after reset.
module mwe_clkdiv #(
    parameter int DIV_SEND = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic rise_tick_o,
    output logic fall_tick_o,
    output logic half_o,
    output logic sclk_o
);
    localparam int PW = (DIV_SEND > 1) ? $clog2(DIV_SEND) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(DIV_SEND - 1);
    localparam int CW = $clog2(2 * DIV_SEND);
    localparam logic [CW-1:0] CHK_LAST = CW'(2 * DIV_SEND - 1);
    localparam logic [CW-1:0] CHK_HALF = CW'(DIV_SEND);

    logic [PW-1:0] ph_q;
    logic          half_q;
    logic          wrap_w;

    assign wrap_w = (ph_q == PH_LAST);

    // Divide-by-DIV_SEND phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      ph_q <= '0;
        else if (wrap_w) ph_q <= '0;
        else             ph_q <= ph_q + 1'b1;
    end

    // Divide-by-two stage: 0 = first half of a bit, 1 = second half.
    always_ff @(posedge clk) begin
        if (!rst_n)      half_q <= 1'b0;
        else if (wrap_w) half_q <= ~half_q;
    end

    assign rise_tick_o = wrap_w & half_q;
    assign fall_tick_o = wrap_w & ~half_q;
    assign half_o      = half_q;
    assign sclk_o      = ~half_q;

    // Free-running shift-period count, used only by the check below.
    logic [CW-1:0] chk_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                 chk_q <= '0;
        else if (chk_q == CHK_LAST) chk_q <= '0;
        else                        chk_q <= chk_q + 1'b1;
    end

    assert_sclk_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o == (chk_q < CHK_HALF));

endmodule

// File: rtl/mwe_framer.sv
// Frame sequencer.
// Keeps the bit-slot position inside a 20-slot frame, decides at falling
// shift-clock edges whether a new frame starts, latches the sync type,
// captures serial data on rising edges, accumulates odd parity, and raises
// the send-data request across the data window.
// Assumes: tick strobes come from mwe_clkdiv; slot 0 is the first sync bit.
module mwe_framer #(
    parameter  int DATA_BITS = 16,
    parameter  int SYNC_BITS = 3,
    localparam int SW        = $clog2(SYNC_BITS + DATA_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_tick_i,
    input  logic          fall_tick_i,
    input  logic          half_i,
    input  logic          enable_i,
    input  logic          sync_sel_i,
    input  logic          sdi_i,
    output logic          busy_o,
    output logic [SW-1:0] slot_o,
    output logic          cmd_o,
    output logic          bit_o,
    output logic          send_data_o
);
    localparam int FRAME_SLOTS = SYNC_BITS + DATA_BITS + 1;
    localparam logic [SW-1:0] SLOT_SYNC_END   = SW'(SYNC_BITS - 1);
    localparam logic [SW-1:0] SLOT_DATA_FIRST = SW'(SYNC_BITS);
    localparam logic [SW-1:0] SLOT_DATA_LAST  = SW'(SYNC_BITS + DATA_BITS - 1);
    localparam logic [SW-1:0] SLOT_PARITY     = SW'(FRAME_SLOTS - 1);
    localparam int WW = $clog2(DATA_BITS + 1);

    logic          pend_q;
    logic          busy_q;
    logic          cmd_q;
    logic          bit_q;
    logic          par_q;
    logic [SW-1:0] slot_q;
    logic          start_w;
    logic          nxt_busy;
    logic [SW-1:0] nxt_slot;
    logic          win_w;

    // Next slot position and busy flag at a rising shift-clock edge.
    always_comb begin
        start_w  = rise_tick_i & pend_q;
        nxt_busy = busy_q;
        nxt_slot = slot_q;
        if (start_w) begin
            nxt_busy = 1'b1;
            nxt_slot = '0;
        end else if (rise_tick_i && busy_q) begin
            if (slot_q == SLOT_PARITY) begin
                nxt_busy = 1'b0;
                nxt_slot = '0;
            end else begin
                nxt_slot = slot_q + 1'b1;
            end
        end
    end

    // Start decision: enable is sampled at a falling edge when idle or in the parity bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (fall_tick_i && (!busy_q || slot_q == SLOT_PARITY))
            pend_q <= enable_i;
        else if (rise_tick_i)
            pend_q <= 1'b0;
    end

    // Slot counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            slot_q <= '0;
        end else begin
            busy_q <= nxt_busy;
            slot_q <= nxt_slot;
        end
    end

    // Sync type latched at the edge that opens a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmd_q <= 1'b0;
        else if (start_w) cmd_q <= sync_sel_i;
    end

    // Data capture on rising edges into data slots; parity loaded for the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
            par_q <= 1'b1;
        end else if (start_w) begin
            par_q <= 1'b1;
        end else if (rise_tick_i && busy_q) begin
            if (nxt_slot >= SLOT_DATA_FIRST && nxt_slot <= SLOT_DATA_LAST) begin
                bit_q <= sdi_i;
                par_q <= par_q ^ sdi_i;
            end else if (nxt_slot == SLOT_PARITY) begin
                bit_q <= par_q;
            end
        end
    end

    // Data window: mid third sync bit up to mid last data bit.
    always_comb begin
        win_w = busy_q &&
                ((slot_q == SLOT_SYNC_END && half_i) ||
                 (slot_q >= SLOT_DATA_FIRST && slot_q < SLOT_DATA_LAST) ||
                 (slot_q == SLOT_DATA_LAST && !half_i));
    end

    assign busy_o      = busy_q;
    assign slot_o      = slot_q;
    assign cmd_o       = cmd_q;
    assign bit_o       = bit_q;
    assign send_data_o = win_w;

    // Count of rising edges seen inside the data window, used by the checks below.
    logic [WW-1:0] win_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)            win_cnt_q <= '0;
        else if (!win_w)       win_cnt_q <= '0;
        else if (rise_tick_i)  win_cnt_q <= win_cnt_q + 1'b1;
    end

    assert_data_window_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(send_data_o) |-> ($past(win_cnt_q) == WW'(DATA_BITS)));

    assert_data_window_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send_data_o) |-> half_i);

    assert_sync_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_w) |-> (cmd_q == $past(sync_sel_i)));

endmodule

// File: rtl/mwe_linedrv.sv
// Line level decoder.
// Maps the frame position, sync type and current bit to a bus condition
// for each half-bit, then to the two active-low line outputs. Inhibit
// blanks the outputs only.
// Assumes: slot/half come from the framer; sync covers slots 0..SYNC_BITS-1.
module mwe_linedrv
    import mwe_pkg::*;
#(
    parameter  int DATA_BITS = 16,
    parameter  int SYNC_BITS = 3,
    localparam int SW        = $clog2(SYNC_BITS + DATA_BITS + 1)
) (
    input  logic          busy_i,
    input  logic [SW-1:0] slot_i,
    input  logic          half_i,
    input  logic          cmd_i,
    input  logic          bit_i,
    input  logic          inhibit_n_i,
    output logic          one_n_o,
    output logic          zero_n_o
);
    localparam int HW = SW + 1;
    localparam logic [HW-1:0] SYNC_HALVES = HW'(2 * SYNC_BITS);
    localparam logic [HW-1:0] SYNC_MID    = HW'(SYNC_BITS);

    logic [HW-1:0] hidx_w;
    line_lvl_e     lvl_w;
    logic          first_w;

    assign hidx_w = {slot_i, half_i};

    // Half-bit bus condition from frame position.
    always_comb begin
        first_w = (hidx_w < SYNC_MID);
        if (!busy_i)
            lvl_w = LVL_IDLE;
        else if (hidx_w < SYNC_HALVES)
            lvl_w = (first_w == cmd_i) ? LVL_POS : LVL_NEG;
        else
            lvl_w = (bit_i ^ half_i) ? LVL_POS : LVL_NEG;
    end

    assign one_n_o  = ~(inhibit_n_i & (lvl_w == LVL_POS));
    assign zero_n_o = ~(inhibit_n_i & (lvl_w == LVL_NEG));

endmodule

// File: rtl/mwe_encoder.sv
// Manchester II word encoder, top level.
// Chains divider -> framer -> line decoder. The framer talks to the serial
// source through the shift clock and the send-data request.
// Assumes: one clock at DIV_SEND*2 times the bit rate; rst_n is synchronous.
module mwe_encoder #(
    parameter int DIV_SEND  = 6,
    parameter int DATA_BITS = 16,
    parameter int SYNC_BITS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic sync_sel_i,
    input  logic sdi_i,
    input  logic inhibit_n_i,
    output logic sclk_o,
    output logic send_data_o,
    output logic line_one_n_o,
    output logic line_zero_n_o
);
    localparam int SLOT_W = $clog2(SYNC_BITS + DATA_BITS + 1);

    logic              rise_tick_w;
    logic              fall_tick_w;
    logic              half_w;
    logic              busy_w;
    logic [SLOT_W-1:0] slot_w;
    logic              cmd_w;
    logic              bit_w;

    mwe_clkdiv #(.DIV_SEND(DIV_SEND)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_tick_o (rise_tick_w),
        .fall_tick_o (fall_tick_w),
        .half_o      (half_w),
        .sclk_o      (sclk_o)
    );

    mwe_framer #(.DATA_BITS(DATA_BITS), .SYNC_BITS(SYNC_BITS)) u_frm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_tick_i (rise_tick_w),
        .fall_tick_i (fall_tick_w),
        .half_i      (half_w),
        .enable_i    (enable_i),
        .sync_sel_i  (sync_sel_i),
        .sdi_i       (sdi_i),
        .busy_o      (busy_w),
        .slot_o      (slot_w),
        .cmd_o       (cmd_w),
        .bit_o       (bit_w),
        .send_data_o (send_data_o)
    );

    mwe_linedrv #(.DATA_BITS(DATA_BITS), .SYNC_BITS(SYNC_BITS)) u_drv (
        .busy_i      (busy_w),
        .slot_i      (slot_w),
        .half_i      (half_w),
        .cmd_i       (cmd_w),
        .bit_i       (bit_w),
        .inhibit_n_i (inhibit_n_i),
        .one_n_o     (line_one_n_o),
        .zero_n_o    (line_zero_n_o)
    );

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!line_one_n_o && !line_zero_n_o));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_w |-> (line_one_n_o && line_zero_n_o && !send_data_o));

endmodule

// File: tb/sim_mwe_encoder.sv
`timescale 1ns/1ps
module sim_mwe_encoder;
    logic clk = 1'b0;
    logic rst_n, enable, sync_sel, sdi, inhibit_n;
    logic sclk, send_data, one_n, zero_n;

    always #10 clk = ~clk;

    mwe_encoder u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .sync_sel_i(sync_sel),
        .sdi_i(sdi), .inhibit_n_i(inhibit_n), .sclk_o(sclk),
        .send_data_o(send_data), .line_one_n_o(one_n), .line_zero_n_o(zero_n)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] words [8] = '{16'hA5C3, 16'h0000, 16'hFFFF, 16'h8001,
                               16'h1234, 16'h7FFE, 16'h5555, 16'h0F0F};
    logic [15:0] cur_word = 16'h0;

    // Behavioural model state: per-clock expectations held in queues.
    int n = 0;
    int mi = 0;
    bit pend = 0;
    int lvl_q[$];
    bit snd_q[$];
    int zone_q[$];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Push 40 half-bits, each 6 clocks: +1 positive, -1 negative.
    task automatic push_frame(input logic [15:0] w, input bit cmd);
        bit p = ~(^w);
        for (int h = 0; h < 40; h++) begin
            int lv;
            int zn;
            bit b;
            if (h < 6) begin
                lv = ((h < 3) == cmd) ? 1 : -1;
                zn = 3;
            end else begin
                b  = (h < 38) ? w[15 - (h - 6) / 2] : p;
                lv = ((h % 2 == 0) == b) ? 1 : -1;
                zn = (h < 38) ? 5 : 7;
            end
            for (int k = 0; k < 6; k++) begin
                lvl_q.push_back(lv);
                snd_q.push_back(h >= 5 && h <= 36);
                zone_q.push_back(zn);
            end
        end
    endtask

    function automatic string zone_tag(input int z);
        case (z)
            3:       return "R2/R3/R8";
            5:       return "R5/R6";
            7:       return "R7";
            default: return "R8/R11";
        endcase
    endfunction

    // Model step and comparison, a quarter period after each rising edge.
    always @(posedge clk) begin
        int  exp_l;
        bit  exp_s;
        int  zone;
        string tl;
        string ts;
        #5;
        exp_l = 0; exp_s = 0; zone = 0;
        if (!rst_n) begin
            n = 0; pend = 0;
            lvl_q.delete(); snd_q.delete(); zone_q.delete();
            tl = "R10"; ts = "R10";
        end else begin
            n++;
            if (n % 12 == 6 && (lvl_q.size() == 0 || lvl_q.size() == 6))
                pend = enable;
            if (n % 12 == 0) begin
                if (pend) begin
                    cur_word = words[mi % 8];
                    push_frame(words[mi % 8], sync_sel);
                    mi++;
                end
                pend = 0;
            end
            if (lvl_q.size() > 0) begin
                exp_l = lvl_q.pop_front();
                exp_s = snd_q.pop_front();
                zone  = zone_q.pop_front();
            end
            tl = inhibit_n ? zone_tag(zone) : "R9";
            ts = (zone == 0) ? "R11" : "R4";
        end
        chk(rst_n ? "R1" : "R10", "sclk", int'(sclk), int'((n / 6) % 2 == 0));
        chk(ts, "send_data", int'(send_data), int'(exp_s));
        chk(tl, "one_n", int'(one_n), int'(!(inhibit_n && exp_l == 1)));
        chk(tl, "zero_n", int'(zero_n), int'(!(inhibit_n && exp_l == -1)));
    end

    // Serial source: MSB on send-data rise, next bit on each shift-clock fall.
    initial begin
        bit psd = 0;
        bit psc = 1;
        int bi  = 0;
        sdi = 1'b0;
        forever begin
            @(negedge clk);
            if (send_data === 1'b1 && !psd) begin
                bi  = 15;
                sdi = cur_word[15];
            end else if (send_data === 1'b1 && psc && sclk === 1'b0) begin
                if (bi > 0) bi--;
                sdi = cur_word[bi];
            end else if (send_data !== 1'b1) begin
                sdi = ~sdi;       // noise outside the window must be ignored (R5)
            end
            psd = (send_data === 1'b1);
            psc = (sclk === 1'b1);
        end
    end

    task automatic wait_clk(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        rst_n = 0; enable = 0; sync_sel = 0; inhibit_n = 1;
        wait_clk(4);
        rst_n = 1;
        wait_clk(30);                                     // idle (R11)
        sync_sel = 1; enable = 1; wait_clk(14); enable = 0; // command frame
        wait_clk(260);
        sync_sel = 0; enable = 1; wait_clk(14); enable = 0; // data frame
        wait_clk(40); sync_sel = 1; wait_clk(240);          // late sync change (R3)
        enable = 1; wait_clk(250); sync_sel = 0;            // back-to-back (R8)
        wait_clk(240); sync_sel = 1; wait_clk(200);
        enable = 0; wait_clk(300);
        enable = 1; wait_clk(14); enable = 0;               // inhibit mid-frame (R9)
        wait_clk(60); inhibit_n = 0; wait_clk(50); inhibit_n = 1;
        wait_clk(200);
        enable = 1; wait_clk(14); enable = 0;               // abort by reset (R10)
        wait_clk(100); rst_n = 0; wait_clk(3); rst_n = 1;
        wait_clk(40);
        enable = 1; wait_clk(1); enable = 0; wait_clk(5);   // short pulses
        enable = 1; wait_clk(1); enable = 0; wait_clk(20);
        sync_sel = 0; enable = 1; wait_clk(14); enable = 0; // recovery frame
        wait_clk(280);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R2: got no end expected end");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule